// File: doc/BRIEF.md
# Cipher-Feedback PCM Sample Cipher Datapath

This block encrypts or decrypts a stream of 8-bit PCM samples in cipher-feedback fashion, eight samples to a 64-bit word. It does not hold the block cipher itself. After each word it presents a 64-bit feedback value to an external cipher engine and raises a request. The engine answers with an ack pulse and a 64-bit keystream block. Byte k of that block, taken from bits 63-8k down to 56-8k, is XORed with sample k of the next word. A format code chooses how many of the top bits of each sample are ciphered. The low bits that are not ciphered are forced to ones before the XOR, and their original values are restored in the output. The feedback word carries those forced ones too.

A mode input chooses the feedback source. In encrypt mode the feedback is the produced ciphertext. In decrypt mode it is the received ciphertext. With the same start state and the same keystream engine, a decrypting instance therefore returns the plaintext that an encrypting instance was given. A `word_sync` pulse brings the two ends back into step. It clears the feedback to zero, restarts the sample count and requests a fresh keystream.

The keystream handshake is a two-state machine. In `KS_WAIT` the request is high. It moves to `KS_HELD` on an ack, unless a word completes or a resync arrives in that same cycle. From `KS_HELD` it returns to `KS_WAIT` when a word completes or a resync arrives. Reset enters `KS_WAIT`. A word is ciphered only if its first sample arrives while the machine is in `KS_HELD`, or in the same cycle as the ack. Otherwise the whole word passes through unciphered and a sticky error flag is raised.

Top module: `cfb_sample_cipher`

## Requirements
- R1: After reset `smp_out_valid` and `ks_err` are 0, `ks_req` is 1 and `ks_fb` is all zeros.
- R2: Format code `fmt` 00 ciphers all 8 bits, 01 the top 7, 10 the top 6 and 11 the top 4. The low 0, 1, 2 or 4 bits of every output sample equal those of its input sample.
- R3: In a ciphered word, the top bits of output sample k are the top bits of (input OR low-bit ones) XOR keystream byte k. Keystream byte k is bits 63-8k down to 56-8k.
- R4: When the eighth sample of a word is accepted, `ks_fb` loads the word's feedback bytes, with sample 0 in bits 63:56. Each byte is the ciphertext with its pass-through bits set to one. In encrypt mode (`dec_mode`=0) the ciphertext is the output sample; in decrypt mode it is the input sample. `ks_fb` holds its value at all other times.
- R5: From the same start state, decrypt mode applied to the encrypt-mode output returns the original samples.
- R6: `ks_req` is 1 from the cycle after a word completes until the cycle after `ks_ack` is seen. It is 0 while a keystream is held.
- R7: A `word_sync` pulse clears `ks_fb` to zero, clears `ks_err`, restarts the word at sample 0 and raises `ks_req` in the next cycle. A sample offered in that same cycle is dropped.
- R8: If the first sample of a word arrives while a keystream is still awaited, `ks_err` becomes 1 and all eight samples of that word are output unchanged. `ks_err` stays 1 until reset or `word_sync`.
- R9: An ack arriving in the same cycle as the first sample of a word supplies that word's keystream. The word is ciphered with it and no error is raised.
- R10: The format code may change between any two samples without a reset; each sample uses the code present when it is accepted.
- R11: `smp_out_valid` is 1 exactly in the cycle after an accepted sample, with `smp_out` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Format code: number of ciphered top bits per sample |
| dec_mode | input | 1 | 0 selects encrypt feedback, 1 selects decrypt feedback |
| word_sync | input | 1 | Resynchronisation pulse |
| smp_valid | input | 1 | Sample offered this cycle |
| smp_in | input | 8 | Input sample |
| smp_out_valid | output | 1 | Output sample valid |
| smp_out | output | 8 | Output sample |
| ks_err | output | 1 | Sticky flag: keystream was missing at a word start |
| ks_req | output | 1 | Keystream request to the cipher engine |
| ks_fb | output | 64 | Feedback word for the cipher engine |
| ks_ack | input | 1 | Keystream ready pulse |
| ks_data | input | 64 | Keystream block, valid with `ks_ack` |

## Verification
Two events can fall in the same cycle: the keystream ack and the first sample of a word. The bench provokes this with a zero-latency engine stub and two words sent back to back. It then checks that the second word is ciphered with the block that just arrived and that `ks_err` stays low. The same back-to-back pattern with a slower stub moves the ack a cycle or more later. That case is judged by `ks_err` rising and by every sample of the word coming back unchanged.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

    localparam int SMP_W        = 8;
    localparam int SMP_PER_WORD = 8;
    localparam int WORD_W       = SMP_W * SMP_PER_WORD;
    localparam int IDX_W        = $clog2(SMP_PER_WORD);

    typedef enum logic [1:0] {
        FMT_ALL8 = 2'b00,
        FMT_TOP7 = 2'b01,
        FMT_TOP6 = 2'b10,
        FMT_TOP4 = 2'b11
    } fmt_e;

    typedef enum logic {
        KS_WAIT = 1'b0,
        KS_HELD = 1'b1
    } ks_state_e;

    // Ones mark the low bits that bypass the cipher.
    function automatic logic [SMP_W-1:0] pass_mask(input logic [1:0] f);
        logic [SMP_W-1:0] m;
        unique case (fmt_e'(f))
            FMT_ALL8: m = SMP_W'(8'h00);
            FMT_TOP7: m = SMP_W'(8'h01);
            FMT_TOP6: m = SMP_W'(8'h03);
            FMT_TOP4: m = SMP_W'(8'h0F);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfb_fmt_mask.sv
module cfb_fmt_mask
    import cfb_pkg::*;
#(
    parameter int SW = SMP_W
) (
    input  logic [SW-1:0] smp,
    input  logic [1:0]    fmt,
    input  logic          dec_mode,
    input  logic          cipher_on,
    input  logic [SW-1:0] key_byte,
    output logic [SW-1:0] res_byte,
    output logic [SW-1:0] fb_byte
);

    logic [SW-1:0] low;
    logic [SW-1:0] forced;
    logic [SW-1:0] mixed;

    always_comb begin
        low    = pass_mask(fmt);
        forced = smp | low;
        mixed  = forced ^ key_byte;
        if (cipher_on) begin
            res_byte = (mixed & ~low) | (smp & low);
        end else begin
            res_byte = smp;
        end
        if (dec_mode) begin
            fb_byte = forced;
        end else begin
            fb_byte = (res_byte & ~low) | low;
        end
    end

endmodule

// File: rtl/cfb_ks_ctrl.sv
module cfb_ks_ctrl
    import cfb_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          resync,
    input  logic          word_done,
    input  logic          ks_ack,
    input  logic [WW-1:0] ks_data,
    output logic          ks_req,
    output logic          ks_have,
    output logic [WW-1:0] ks_word
);

    ks_state_e st_q;
    ks_state_e st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= KS_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            KS_WAIT: begin
                if (resync || word_done) begin
                    st_d = KS_WAIT;
                end else if (ks_ack) begin
                    st_d = KS_HELD;
                end
            end
            KS_HELD: begin
                if (resync || word_done) begin
                    st_d = KS_WAIT;
                end
            end
        endcase
    end

    always_comb begin
        ks_req  = (st_q == KS_WAIT);
        ks_have = (st_q == KS_HELD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ks_word <= '0;
        end else if (st_q == KS_WAIT && ks_ack && !resync && !word_done) begin
            ks_word <= ks_data;
        end
    end

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_req && !ks_ack) |=> ks_req);

    // R6
    req_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> ks_req);

endmodule

// File: rtl/cfb_word_asm.sv
module cfb_word_asm
    import cfb_pkg::*;
#(
    parameter  int SW   = SMP_W,
    parameter  int NS   = SMP_PER_WORD,
    localparam int WW   = SW * NS,
    localparam int IW   = $clog2(NS),
    localparam int PW   = WW - SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          resync,
    input  logic          take,
    input  logic [SW-1:0] fb_byte,
    output logic [IW-1:0] idx,
    output logic          word_done,
    output logic [WW-1:0] fb_word
);

    localparam logic [IW-1:0] LAST = IW'(NS - 1);

    logic [PW-1:0] part_q;
    logic [PW-1:0] part_d;

    assign word_done = take && (idx == LAST);

    generate
        if (PW > SW) begin : g_shift
            assign part_d = {part_q[PW-SW-1:0], fb_byte};
        end else begin : g_load
            assign part_d = fb_byte;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || resync) begin
            idx     <= '0;
            part_q  <= '0;
            fb_word <= '0;
        end else if (take) begin
            idx    <= word_done ? '0 : idx + 1'b1;
            part_q <= part_d;
            if (word_done) begin
                fb_word <= {part_q, fb_byte};
            end
        end
    end

    // R4
    fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_done && !resync) |=> $stable(fb_word));

endmodule

// File: rtl/cfb_sample_cipher.sv
module cfb_sample_cipher
    import cfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt,
    input  logic              dec_mode,
    input  logic              word_sync,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_in,
    output logic              smp_out_valid,
    output logic [SMP_W-1:0]  smp_out,
    output logic              ks_err,
    output logic              ks_req,
    output logic [WORD_W-1:0] ks_fb,
    input  logic              ks_ack,
    input  logic [WORD_W-1:0] ks_data
);

    logic              take;
    logic              ack_now;
    logic              first_smp;
    logic              cipher_now;
    logic              word_en_q;
    logic              word_done;
    logic              ks_have;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] ks_word;
    logic [WORD_W-1:0] key_src;
    logic [SMP_W-1:0]  key_byte;
    logic [SMP_W-1:0]  res_byte;
    logic [SMP_W-1:0]  fb_byte;
    logic [SMP_W-1:0]  key_lane [SMP_PER_WORD];

    assign take      = smp_valid && !word_sync;
    assign ack_now   = ks_req && ks_ack;
    assign first_smp = (idx == '0);
    assign key_src   = ack_now ? ks_data : ks_word;

    for (genvar g = 0; g < SMP_PER_WORD; g++) begin : g_lane
        assign key_lane[g] = key_src[WORD_W-1-g*SMP_W -: SMP_W];
    end

    always_comb begin
        key_byte   = key_lane[idx];
        cipher_now = first_smp ? (ks_have || ack_now) : word_en_q;
    end

    cfb_ks_ctrl #(.WW(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .resync   (word_sync),
        .word_done(word_done),
        .ks_ack   (ks_ack),
        .ks_data  (ks_data),
        .ks_req   (ks_req),
        .ks_have  (ks_have),
        .ks_word  (ks_word)
    );

    cfb_fmt_mask #(.SW(SMP_W)) u_mask (
        .smp      (smp_in),
        .fmt      (fmt),
        .dec_mode (dec_mode),
        .cipher_on(cipher_now),
        .key_byte (key_byte),
        .res_byte (res_byte),
        .fb_byte  (fb_byte)
    );

    cfb_word_asm #(.SW(SMP_W), .NS(SMP_PER_WORD)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .resync   (word_sync),
        .take     (take),
        .fb_byte  (fb_byte),
        .idx      (idx),
        .word_done(word_done),
        .fb_word  (ks_fb)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_out_valid <= 1'b0;
            smp_out       <= '0;
            word_en_q     <= 1'b0;
            ks_err        <= 1'b0;
        end else begin
            smp_out_valid <= take;
            if (take) begin
                smp_out <= res_byte;
            end
            if (word_sync) begin
                word_en_q <= 1'b0;
                ks_err    <= 1'b0;
            end else if (take && first_smp) begin
                word_en_q <= cipher_now;
                if (!cipher_now) begin
                    ks_err <= 1'b1;
                end
            end
        end
    end

    // R11
    out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> smp_out_valid);

    // R11
    out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !smp_out_valid);

    // R2
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_out_valid |-> (((smp_out ^ $past(smp_in)) & pass_mask($past(fmt))) == '0));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_err && !word_sync) |=> ks_err);

    // R8
    err_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ks_err) |-> (smp_out == $past(smp_in)));

    // R7
    resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_sync |=> (ks_fb == '0 && ks_req && !ks_err && !smp_out_valid));

endmodule

// File: tb/sim_cfb_sample_cipher.sv
module sim_cfb_sample_cipher;
    import cfb_pkg::*;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        dec_mode = 1'b0;
    logic        word_sync = 1'b0;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_in = 8'h00;
    logic        smp_out_valid;
    logic [7:0]  smp_out;
    logic        ks_err;
    logic        ks_req;
    logic [63:0] ks_fb;
    logic        ks_ack = 1'b0;
    logic [63:0] ks_data = 64'h0;

    cfb_sample_cipher u0 (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .dec_mode(dec_mode),
        .word_sync(word_sync), .smp_valid(smp_valid), .smp_in(smp_in),
        .smp_out_valid(smp_out_valid), .smp_out(smp_out), .ks_err(ks_err),
        .ks_req(ks_req), .ks_fb(ks_fb), .ks_ack(ks_ack), .ks_data(ks_data)
    );

    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;
    int   stub_lat = 3;
    bit   stub_en = 1'b0;
    int   stub_cnt = 0;
    logic [63:0] m_fb = 64'h0;
    logic [63:0] m_word = 64'h0;
    logic [63:0] m_key = 64'h0;
    int   m_idx = 0;
    bit   m_on = 1'b1;
    bit   g_on = 1'b1;
    logic [7:0] last_out;

    function automatic logic [63:0] ksf(input logic [63:0] v);
        return ({v[58:0], v[63:59]} ^ 64'h9E37_79B9_7F4A_7C15) + {v[31:0], v[63:32]};
    endfunction

    function automatic logic [7:0] lowm(input logic [1:0] f);
        case (f)
            2'b00:   return 8'h00;
            2'b01:   return 8'h01;
            2'b10:   return 8'h03;
            default: return 8'h0F;
        endcase
    endfunction

    // Cipher engine stub: acks after stub_lat negedges of pending request.
    always @(negedge clk) begin
        if (ks_ack) begin
            ks_ack = 1'b0;
            stub_cnt = 0;
        end else if (stub_en && ks_req) begin
            if (stub_cnt >= stub_lat) begin
                ks_ack = 1'b1;
                ks_data = ksf(ks_fb);
            end else begin
                stub_cnt++;
            end
        end else begin
            stub_cnt = 0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic push(input logic [7:0] b, input string tag);
        logic [7:0] low, kb, exp, fbb;
        low = lowm(fmt);
        if (m_idx == 0) begin
            m_on  = g_on;
            m_key = ksf(m_fb);
        end
        kb  = m_key[63-8*m_idx -: 8];
        exp = m_on ? ((((b | low) ^ kb) & ~low) | (b & low)) : b;
        fbb = dec_mode ? (b | low) : ((exp & ~low) | low);
        m_word = {m_word[55:0], fbb};
        m_idx++;
        if (m_idx == 8) begin
            m_idx = 0;
            m_fb  = m_word;
        end
        smp_in = b;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        chk(tag, {55'd0, smp_out_valid, smp_out}, {55'd0, 1'b1, exp});
        last_out = smp_out;
    endtask

    task automatic wait_key();
        for (int i = 0; i < 100 && ks_req; i++) @(negedge clk);
    endtask

    task automatic do_resync();
        word_sync = 1'b1;
        @(negedge clk);
        word_sync = 1'b0;
        m_fb = 64'h0;
        m_idx = 0;
    endtask

    task automatic t_reset();
        stub_en = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_fb = 64'h0;
        m_idx = 0;
        @(negedge clk);
        chk("R1 out_valid", {63'd0, smp_out_valid}, 64'd0);
        chk("R1 err", {63'd0, ks_err}, 64'd0);
        chk("R1 req", {63'd0, ks_req}, 64'd1);
        chk("R1 fb", ks_fb, 64'h0);
        stub_en = 1'b1;
        stub_lat = 3;
    endtask

    task automatic t_encrypt();
        fmt = 2'b00;
        dec_mode = 1'b0;
        wait_key();
        chk("R6 req low when held", {63'd0, ks_req}, 64'd0);
        for (int i = 0; i < 8; i++) push(8'(8'h11 * i + 8'h3C), "R3 encrypt fmt00");
        chk("R6 req after word", {63'd0, ks_req}, 64'd1);
        chk("R4 feedback word", ks_fb, m_fb);
        @(negedge clk);
        chk("R11 no output without sample", {63'd0, smp_out_valid}, 64'd0);
        chk("R6 req held until ack", {63'd0, ks_req}, 64'd1);
        wait_key();
        chk("R4 feedback stable", ks_fb, m_fb);
    endtask

    task automatic t_formats();
        for (int f = 0; f < 4; f++) begin
            fmt = 2'(f);
            for (int i = 0; i < 8; i++) begin
                logic [7:0] b;
                b = 8'(f * 37 + i * 29 + 5);
                push(b, "R2 format word");
                chk("R2 low bits kept", {56'd0, last_out & lowm(fmt)}, {56'd0, b & lowm(fmt)});
            end
            wait_key();
            chk("R4 feedback per format", ks_fb, m_fb);
        end
    endtask

    task automatic t_fmt_change();
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            fmt = 2'(i % 4);
            b = 8'(8'hF0 ^ 8'(i * 23));
            push(b, "R10 format change mid-word");
            chk("R10 low bits kept", {56'd0, last_out & lowm(fmt)}, {56'd0, b & lowm(fmt)});
        end
        wait_key();
        chk("R10 feedback", ks_fb, m_fb);
    endtask

    task automatic t_roundtrip();
        logic [7:0] pt [16];
        logic [7:0] ct [16];
        fmt = 2'b01;
        dec_mode = 1'b0;
        do_resync();
        wait_key();
        for (int i = 0; i < 16; i++) begin
            pt[i] = 8'(i * 53 + 7);
            push(pt[i], "R3 encrypt fmt01");
            ct[i] = last_out;
            if (i == 7) wait_key();
        end
        wait_key();
        dec_mode = 1'b1;
        do_resync();
        wait_key();
        for (int i = 0; i < 16; i++) begin
            push(ct[i], "R4 decrypt model");
            chk("R5 decrypt returns plaintext", {56'd0, last_out}, {56'd0, pt[i]});
            if (i == 7) wait_key();
        end
        wait_key();
        chk("R4 decrypt feedback", ks_fb, m_fb);
        dec_mode = 1'b0;
    endtask

    task automatic t_same_cycle();
        fmt = 2'b00;
        stub_lat = 0;
        do_resync();
        wait_key();
        for (int i = 0; i < 8; i++) push(8'(i * 17 + 1), "R3 word before coincident ack");
        for (int i = 0; i < 8; i++) push(8'(i * 41 + 9), "R9 ack with first sample");
        chk("R9 no error", {63'd0, ks_err}, 64'd0);
        wait_key();
    endtask

    task automatic t_missing();
        fmt = 2'b10;
        stub_lat = 12;
        do_resync();
        wait_key();
        for (int i = 0; i < 8; i++) push(8'(i * 13 + 2), "R3 word before missing key");
        g_on = 1'b0;
        for (int i = 0; i < 8; i++) begin
            push(8'(i * 31 + 100), "R8 word passes unciphered");
            chk("R8 error raised", {63'd0, ks_err}, 64'd1);
        end
        g_on = 1'b1;
        wait_key();
        chk("R8 error sticky", {63'd0, ks_err}, 64'd1);
        chk("R4 feedback after bypass word", ks_fb, m_fb);
        word_sync = 1'b1;
        smp_valid = 1'b1;
        smp_in = 8'hAA;
        @(negedge clk);
        word_sync = 1'b0;
        smp_valid = 1'b0;
        m_fb = 64'h0;
        m_idx = 0;
        chk("R7 sample dropped", {63'd0, smp_out_valid}, 64'd0);
        chk("R7 err cleared", {63'd0, ks_err}, 64'd0);
        chk("R7 fb cleared", ks_fb, 64'h0);
        chk("R7 req raised", {63'd0, ks_req}, 64'd1);
        wait_key();
        for (int i = 0; i < 8; i++) push(8'(i * 7 + 60), "R7 first word after resync");
    endtask

    initial begin
        t_reset();
        t_encrypt();
        t_formats();
        t_fmt_change();
        t_roundtrip();
        t_same_cycle();
        t_missing();
        repeat (2) @(negedge clk);
        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule